// File: doc/BRIEF.md
# Delimited Byte-Stream Framer with Escape Insertion

This block sits between a payload source and the transmit FIFO of a serial port. Payload bytes arrive on a valid/ready/last stream. The block writes them into the FIFO, one byte per cycle at most. It wraps each frame in a start-of-text delimiter (0x02) at both ends. In stuffed mode it also places a data-link-escape byte (0x10) ahead of any payload byte that would otherwise be read as a delimiter or as an escape. In plain mode the payload passes through unchanged between the two delimiters.

The FIFO full flag cannot be trusted. For this reason the block writes in bursts, and each burst starts only when the FIFO reports empty. Within a burst the block counts its own writes against the FIFO depth. It accepts a payload byte only while enough entries remain for the worst case that can follow: an escape pair plus the closing delimiter in stuffed mode, or the closing delimiter alone in plain mode. When the budget runs out before the last payload byte, the burst ends and the frame stays open. The next burst, after the FIFO has emptied again, carries on with the same frame and sends no second opening delimiter.

Top module: `stx_dle_framer`

## Requirements
- R1: While reset is held and after it is released, `fifo_wr` and `in_ready` stay low until a burst begins, and no frame is open.
- R2: The first write of a frame is the opening delimiter 0x02. It is written only when no frame is open, and `in_ready` is low in that cycle.
- R3: In stuffed mode (`stuff_en`=1), a payload byte of 0x02 or 0x10 is preceded by an escape byte 0x10. The escape is written with `in_ready` low. The data byte is written on the next cycle in which `in_valid` is high, with `in_ready` high.
- R4: In plain mode (`stuff_en`=0), no escape byte is inserted, and payload bytes 0x02 and 0x10 are written as they are.
- R5: In the cycle after the byte flagged `in_last` is accepted, a closing 0x02 is written, the frame is closed, and the burst ends.
- R6: In stuffed mode, a payload byte is taken up only while fewer than DEPTH-2 (62) entries have been written in the current burst. Otherwise the burst ends.
- R7: In plain mode, a payload byte is taken up only while fewer than DEPTH-1 (63) entries have been written in the current burst.
- R8: When idle, the block starts a burst only in a cycle where `in_valid` and `fifo_empty` are both high. The first write follows one cycle later.
- R9: A frame interrupted by an exhausted budget stays open. The following burst resumes it without a new opening delimiter.
- R10: A burst that starts on an empty FIFO never writes more than DEPTH (64) entries, so the FIFO cannot overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stuff_en | input | 1 | 1 selects stuffed mode, 0 selects plain mode |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte present |
| in_last | input | 1 | Payload byte ends the frame |
| in_ready | output | 1 | Payload byte taken this cycle |
| fifo_empty | input | 1 | Transmit FIFO holds no entries |
| fifo_data | output | 8 | Byte written into the FIFO |
| fifo_wr | output | 1 | Write strobe for the FIFO |

## Verification
`fifo_wr`, `fifo_data` and `in_ready` are combinational functions of the registered phase and of the inputs in the same cycle. Flag changes (frame open, escape pending, close pending, burst count) take effect at the next edge. A burst's first write therefore comes one cycle after the cycle that saw `fifo_empty`. The escaped data byte follows its escape by one cycle, and the closing delimiter follows the last accepted byte by one cycle. The bench drives inputs on the falling edge and samples the outputs 1 ns later, against a behavioural model stepped once per cycle. At the end of each frame it also compares the whole captured byte stream with the expected framing built from the payload.

// File: rtl/fenc_pkg.sv
`timescale 1ns/1ps
// Shared constants and types of the delimited framer.
// Assumes byte-wide symbols; the two marker values are fixed by the line protocol.
package fenc_pkg;
    localparam logic [7:0] SYM_STX = 8'h02;
    localparam logic [7:0] SYM_DLE = 8'h10;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_BURST = 1'b1
    } phase_t;
endpackage

// File: rtl/fenc_escape_detect.sv
`timescale 1ns/1ps
// Flags a payload byte that must be escaped before it goes on the line.
// Assumes: escaping applies only in stuffed mode; purely combinational.
module fenc_escape_detect
    import fenc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] byte_i,
    input  logic         stuff_i,
    output logic         need_esc_o
);
    // Match against both reserved symbols when stuffing is on.
    always_comb begin
        need_esc_o = stuff_i && ((byte_i == W'(SYM_STX)) || (byte_i == W'(SYM_DLE)));
    end
endmodule

// File: rtl/fenc_burst_budget.sv
`timescale 1ns/1ps
// Counts FIFO writes within one burst and reports whether another payload
// byte may be taken up. Assumes the burst began on an empty FIFO, so the
// count is an upper bound on occupancy. Stuffed mode reserves two entries
// (escape pair tail plus closing delimiter); plain mode reserves one.
module fenc_burst_budget #(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             bump_i,
    input  logic             stuff_i,
    output logic             room_o,
    output logic [CNT_W-1:0] count_o
);
    localparam int RESERVE_STUFF = 2;
    localparam int RESERVE_PLAIN = 1;
    localparam logic [CNT_W-1:0] LIM_STUFF = CNT_W'(DEPTH - RESERVE_STUFF);
    localparam logic [CNT_W-1:0] LIM_PLAIN = CNT_W'(DEPTH - RESERVE_PLAIN);

    logic [CNT_W-1:0] count_q;

    // Burst write counter: cleared at burst start, bumped on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (clear_i) count_q <= '0;
        else if (bump_i)  count_q <= count_q + 1'b1;
    end

    // Room test against the mode's limit.
    always_comb begin
        room_o  = count_q < (stuff_i ? LIM_STUFF : LIM_PLAIN);
        count_o = count_q;
    end

    // R10: a write never lands once DEPTH entries have gone out in this burst.
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        bump_i |-> (count_q < CNT_W'(DEPTH)));
endmodule

// File: rtl/stx_dle_framer.sv
`timescale 1ns/1ps
// Streaming transmit framer. Wraps each payload frame in STX delimiters and,
// in stuffed mode, escapes payload STX/DLE bytes with a DLE. Writes in bursts
// that start only on an empty FIFO, keeping a per-burst write budget so the
// escape tail and closing delimiter always fit. A frame that outlives a
// burst stays open and is resumed by the next burst.
// Assumes: in_data/in_last hold steady while in_valid is high and unaccepted.
module stx_dle_framer
    import fenc_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stuff_en,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    output logic       in_ready,
    input  logic       fifo_empty,
    output logic [7:0] fifo_data,
    output logic       fifo_wr
);
    phase_t           phase_q, phase_d;
    logic             open_q, open_d;
    logic             esc_q, esc_d;
    logic             close_q, close_d;
    logic             need_esc;
    logic             room;
    logic             budget_clear;
    logic [CNT_W-1:0] burst_cnt;

    fenc_escape_detect #(.W(8)) u_esc (
        .byte_i     (in_data),
        .stuff_i    (stuff_en),
        .need_esc_o (need_esc)
    );

    fenc_burst_budget #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (budget_clear),
        .bump_i  (fifo_wr),
        .stuff_i (stuff_en),
        .room_o  (room),
        .count_o (burst_cnt)
    );

    // Next-state and output decode, one FIFO write per cycle at most.
    always_comb begin
        phase_d      = phase_q;
        open_d       = open_q;
        esc_d        = esc_q;
        close_d      = close_q;
        budget_clear = 1'b0;
        fifo_wr      = 1'b0;
        fifo_data    = in_data;
        in_ready     = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (in_valid && fifo_empty) begin
                    phase_d      = PH_BURST;
                    budget_clear = 1'b1;
                end
            end
            PH_BURST: begin
                if (!open_q) begin
                    fifo_wr   = 1'b1;
                    fifo_data = SYM_STX;
                    open_d    = 1'b1;
                end else if (esc_q) begin
                    if (in_valid) begin
                        fifo_wr  = 1'b1;
                        in_ready = 1'b1;
                        esc_d    = 1'b0;
                        close_d  = in_last;
                    end
                end else if (close_q) begin
                    fifo_wr   = 1'b1;
                    fifo_data = SYM_STX;
                    open_d    = 1'b0;
                    close_d   = 1'b0;
                    phase_d   = PH_IDLE;
                end else if (!room) begin
                    phase_d = PH_IDLE;
                end else if (in_valid) begin
                    fifo_wr = 1'b1;
                    if (need_esc) begin
                        fifo_data = SYM_DLE;
                        esc_d     = 1'b1;
                    end else begin
                        in_ready = 1'b1;
                        close_d  = in_last;
                    end
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Framing state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            open_q  <= 1'b0;
            esc_q   <= 1'b0;
            close_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            open_q  <= open_d;
            esc_q   <= esc_d;
            close_q <= close_d;
        end
    end

    // R8: nothing is written or accepted while idle.
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE) |-> (!fifo_wr && !in_ready));

    // R2: a frame opens only through a written STX.
    a_r2_open_by_stx: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_q) |-> $past(fifo_wr && (fifo_data == SYM_STX)));

    // R5: a frame closes only through a written STX.
    a_r5_close_by_stx: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(open_q) |-> $past(fifo_wr && (fifo_data == SYM_STX)));

    // R3: a pending escape resolves into the reserved data byte, taken as written.
    a_r3_escape_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (esc_q && in_valid) |-> (fifo_wr && in_ready &&
            ((in_data == SYM_STX) || (in_data == SYM_DLE))));

    // R4: an accepted byte always goes to the FIFO unchanged in the same cycle.
    a_r4_accept_writes: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (fifo_wr && (fifo_data == in_data)));

    // R6: the escape pair never begins outside the stuffed budget.
    a_r6_escape_budget: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(esc_q) |-> ($past(burst_cnt) < CNT_W'(DEPTH - 2)));
endmodule

// File: tb/sim_stx_dle_framer.sv
`timescale 1ns/1ps
module sim_stx_dle_framer;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stuff_en = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       fifo_empty = 1'b1;
    logic [7:0] fifo_data;
    logic       fifo_wr;

    always #2.5 clk = ~clk;

    stx_dle_framer #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .stuff_en(stuff_en),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
        .in_ready(in_ready), .fifo_empty(fifo_empty),
        .fifo_data(fifo_data), .fifo_wr(fifo_wr)
    );

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    int occ      = 0;
    bit mode     = 1'b0;
    bit gap_on   = 1'b0;

    logic [7:0] pq[$];
    bit         lq[$];
    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];

    // Behavioural reference state.
    bit m_act, m_open, m_esc, m_close;
    int m_cnt;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, expv, expv);
        end
    endtask

    // Queue a frame for the driver and record its expected line bytes.
    task automatic add_frame(input logic [7:0] pl[$], input bit st);
        exp_q.push_back(8'h02);
        foreach (pl[i]) begin
            if (st && (pl[i] == 8'h02 || pl[i] == 8'h10)) exp_q.push_back(8'h10);
            exp_q.push_back(pl[i]);
            pq.push_back(pl[i]);
            lq.push_back(i == pl.size() - 1);
        end
        exp_q.push_back(8'h02);
    endtask

    task automatic step();
        bit e_wr, e_rdy, sp;
        logic [7:0] e_d;
        string tag;
        int lim;
        @(negedge clk);
        cyc++;
        in_valid   = (pq.size() > 0) && !(gap_on && (cyc % 4 == 1));
        in_data    = (pq.size() > 0) ? pq[0] : 8'h00;
        in_last    = (pq.size() > 0) ? lq[0] : 1'b0;
        fifo_empty = (occ == 0);
        stuff_en   = mode;
        #1;
        e_wr = 0; e_rdy = 0; e_d = 8'h00; tag = "R8";
        lim = mode ? DEPTH - 2 : DEPTH - 1;
        sp  = (in_data == 8'h02) || (in_data == 8'h10);
        if (!m_act) begin
            if (in_valid && fifo_empty) begin m_act = 1; m_cnt = 0; end
        end else if (!m_open) begin
            e_wr = 1; e_d = 8'h02; m_open = 1; m_cnt++; tag = "R2";
        end else if (m_esc) begin
            tag = "R3";
            if (in_valid) begin
                e_wr = 1; e_rdy = 1; e_d = in_data; m_esc = 0; m_cnt++;
                if (in_last) m_close = 1;
            end
        end else if (m_close) begin
            e_wr = 1; e_d = 8'h02; m_open = 0; m_close = 0; m_act = 0; tag = "R5";
        end else if (m_cnt >= lim) begin
            m_act = 0; tag = mode ? "R6" : "R7";
        end else if (in_valid) begin
            if (mode && sp) begin
                e_wr = 1; e_d = 8'h10; m_esc = 1; m_cnt++; tag = "R3";
            end else begin
                e_wr = 1; e_rdy = 1; e_d = in_data; m_cnt++;
                if (in_last) m_close = 1;
                tag = mode ? "R6" : "R4";
            end
        end
        check(fifo_wr == e_wr, {tag, " write strobe"}, fifo_wr, e_wr);
        check(in_ready == e_rdy, {tag, " ready"}, in_ready, e_rdy);
        if (e_wr) check(fifo_data == e_d, {tag, " data"}, fifo_data, e_d);
        if (fifo_wr) begin
            got_q.push_back(fifo_data);
            occ++;
            check(occ <= DEPTH, "R10 occupancy", occ, DEPTH);
        end
        if (in_ready && in_valid) begin
            void'(pq.pop_front());
            void'(lq.pop_front());
        end
        if (occ > 0 && (cyc % 3 == 0)) occ--;
    endtask

    task automatic run_frames(input string tag);
        int guard;
        guard = 0;
        while ((pq.size() > 0 || m_act) && guard < 20000) begin
            step();
            guard++;
        end
        check(got_q.size() == exp_q.size(), {tag, " stream length"}, got_q.size(), exp_q.size());
        if (got_q.size() == exp_q.size())
            foreach (exp_q[i]) check(got_q[i] == exp_q[i], {tag, " stream byte"}, got_q[i], exp_q[i]);
        got_q.delete();
        exp_q.delete();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [7:0] pl[$];
        m_act = 0; m_open = 0; m_esc = 0; m_close = 0; m_cnt = 0;
        // R1: quiet during and after reset.
        repeat (3) begin
            @(negedge clk); #1;
            check(!fifo_wr, "R1 write in reset", fifo_wr, 0);
            check(!in_ready, "R1 ready in reset", in_ready, 0);
        end
        @(negedge clk); rst_n = 1'b1;
        repeat (3) step();

        // Stuffed frame with both reserved values: R3, R2, R5.
        mode = 1; pl = '{8'h41, 8'h02, 8'h10, 8'h7F};
        add_frame(pl, 1); run_frames("R3");

        // Same payload in plain mode: R4.
        mode = 0; add_frame(pl, 0); run_frames("R4");

        // Gapped input with back-to-back frames: R3, R5.
        mode = 1; gap_on = 1;
        pl = '{8'h10, 8'h10, 8'h02, 8'h55}; add_frame(pl, 1);
        pl = '{8'h10}; add_frame(pl, 1);
        run_frames("R5"); gap_on = 0;

        // Long stuffed frame that overruns one burst: R6, R9.
        pl.delete();
        for (int i = 0; i < 150; i++) pl.push_back(8'((i * 7) % 20));
        add_frame(pl, 1); run_frames("R9");

        // Long plain frame: R7, R9.
        mode = 0; pl.delete();
        for (int i = 0; i < 140; i++) pl.push_back(8'(i));
        add_frame(pl, 0); run_frames("R7");

        // Burst start waits for an empty FIFO: R8.
        mode = 1; occ = 20; pl = '{8'h33, 8'h02}; add_frame(pl, 1);
        repeat (10) step();
        check(got_q.size() == 0, "R8 no write before empty", got_q.size(), 0);
        run_frames("R8");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule